// File: doc/BRIEF.md
# Compare Timer with Prescaled Up-Counter

This block is a register-mapped timer. An up-counter, whose width is a build parameter, counts from zero up to a programmable modulo value and then returns to zero. It advances only while its run bit is set, and then only on ticks from a power-of-two prescaler. Software can read the counter width from a read-only parameter register. It sets up the prescaler and the modulo value, and it can restart the count by writing to the counter register.

A single output-compare channel watches the counter. When the channel is in software-compare mode and the counter reaches the compare value on a tick, a channel flag is set. The interrupt line is high while that flag is set and the channel interrupt enable is on. The overflow flag and the channel flag are both cleared by writing one to them, and they sit in registers that also hold ordinary read/write control fields. The bus is a plain synchronous register port: address, write strobe, write data, and read data that follows the address combinationally.

Top module: `cmp_timer`

## Requirements
- R1: A synchronous active-high reset clears every control, flag, counter and compare field, sets the modulo field to all ones, and drives `irq` low. The register at offset 0x04 reads the counter width in bits 23:16, so the default 16-bit build reads 0x00100000.
- R2: The counter holds its value while bit 3 (run) of the control register at 0x10 is zero, and counts while it is one.
- R3: With prescaler code n in bits 2:0 of the control register, the counter, readable at offset 0x14, advances once every 2^n clocks. Code 0 advances every clock and code 7 every 128 clocks.
- R4: On a tick with the count equal to the modulo value (offset 0x18), the count becomes zero and the overflow flag (bit 7 of 0x10) sets. Writing 1 to that bit clears the flag, and writing 0 to it leaves the flag alone.
- R5: Any write to offset 0x14 sets the count to zero and restarts the prescaler phase, whatever the write data.
- R6: When the channel mode (bits 5:2 of the channel control register at 0x20) is 4, the channel flag (bit 7 of 0x20) sets in the same cycle as the count becomes equal to the compare value (offset 0x24) on a tick. With any other mode, including 0, the flag never sets.
- R7: Bit 0 of the status register at 0x1C reads the channel flag. Writing 1 to either that bit or bit 7 of 0x20 clears the flag, and writing 0 to them does not.
- R8: `irq` is high exactly while the channel flag and the interrupt enable (bit 6 of 0x20) are both set, and it stays high until the flag is cleared or the enable is dropped.
- R9: Reads of unmapped offsets return zero, and unused bits of mapped registers read zero whatever was written to them.
- R10: If a compare match and a clear of the channel flag happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Channel interrupt request |

## Verification
Several properties are checked by assertions on every cycle. A stopped counter holds its value. A write to the counter register zeroes it. A tick at the modulo value wraps the count and sets the overflow flag. The channel flag never rises while the mode is not software compare. An asserted interrupt stays high until a bus write could have cleared it. Other behaviour can only be seen in the bench's scenarios. This covers the exact tick spacing of each prescaler code, the match cycle relative to the counter value, the effect of write-one-to-clear versus writing zero, the case where a match and a clear land in the same cycle, and the read-back of unmapped offsets and unused bits. For these the bench compares the whole register file and the interrupt against a behavioural model every clock.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam logic [7:0] OFS_PARAM  = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_MODULO = 8'h18;
    localparam logic [7:0] OFS_STATUS = 8'h1C;
    localparam logic [7:0] OFS_CHCTL  = 8'h20;
    localparam logic [7:0] OFS_CHVAL  = 8'h24;

    localparam int PS_BITS = 3;
    localparam int MODE_BITS = 4;
    localparam logic [MODE_BITS-1:0] MODE_SWCMP = 4'h4;
endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
    parameter int PS_BITS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic [PS_BITS-1:0] code,
    output logic               tick
);
    localparam int DIV_W = (1 << PS_BITS) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = (DIV_W'(1) << code) - DIV_W'(1);
        tick = run && !restart && ((st_q.div & mask) == mask);
        st_d = st_q;
        if (restart || !run) st_d.div = '0;
        else                 st_d.div = st_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tick |-> run); // R2
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             zero,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        wrap = tick && (st_q.cnt == modulo);
        st_d = st_q;
        if (zero)      st_d.cnt = '0;
        else if (wrap) st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        count      = st_q.cnt;
        count_next = st_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !zero) |=> $stable(count)); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && count == modulo) |=> (count == '0)); // R4
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import cmp_timer_pkg::*;

    localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

    typedef struct packed {
        logic [PS_BITS-1:0]   presc;
        logic                 run;
        logic                 ovf;
        logic [MODE_BITS-1:0] mode;
        logic                 ie;
        logic                 chf;
        logic [CNT_W-1:0]     modv;
        logic [CNT_W-1:0]     cmpv;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    logic tick, wrap, hit;
    logic wr_ctrl, wr_count, wr_mod, wr_stat, wr_chctl, wr_chval;
    logic [CNT_W-1:0] count, count_next;

    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
        wr_count = bus_we && (bus_addr == OFS_COUNT);
        wr_mod   = bus_we && (bus_addr == OFS_MODULO);
        wr_stat  = bus_we && (bus_addr == OFS_STATUS);
        wr_chctl = bus_we && (bus_addr == OFS_CHCTL);
        wr_chval = bus_we && (bus_addr == OFS_CHVAL);
    end

    cmp_timer_presc #(.PS_BITS(PS_BITS)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (rs_q.run),
        .restart (wr_count),
        .code    (rs_q.presc),
        .tick    (tick)
    );

    cmp_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .zero       (wr_count),
        .modulo     (rs_q.modv),
        .count      (count),
        .count_next (count_next),
        .wrap       (wrap)
    );

    always_comb begin
        hit  = tick && (rs_q.mode == MODE_SWCMP) && (count_next == rs_q.cmpv);
        rs_d = rs_q;
        if (wr_ctrl) begin
            rs_d.run   = bus_wdata[3];
            rs_d.presc = bus_wdata[PS_BITS-1:0];
            if (bus_wdata[7]) rs_d.ovf = 1'b0;
        end
        if (wrap) rs_d.ovf = 1'b1;
        if (wr_mod)   rs_d.modv = bus_wdata[CNT_W-1:0];
        if (wr_chval) rs_d.cmpv = bus_wdata[CNT_W-1:0];
        if (wr_chctl) begin
            rs_d.mode = bus_wdata[5:2];
            rs_d.ie   = bus_wdata[6];
            if (bus_wdata[7]) rs_d.chf = 1'b0;
        end
        if (wr_stat && bus_wdata[0]) rs_d.chf = 1'b0;
        if (hit) rs_d.chf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q      <= '0;
            rs_q.modv <= '1;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_PARAM:  bus_rdata[23:16] = WIDTH_CODE;
            OFS_CTRL:   bus_rdata[7:0] = {rs_q.ovf, 3'b000, rs_q.run, rs_q.presc};
            OFS_COUNT:  bus_rdata[CNT_W-1:0] = count;
            OFS_MODULO: bus_rdata[CNT_W-1:0] = rs_q.modv;
            OFS_STATUS: bus_rdata[0] = rs_q.chf;
            OFS_CHCTL:  bus_rdata[7:0] = {rs_q.chf, rs_q.ie, rs_q.mode, 2'b00};
            OFS_CHVAL:  bus_rdata[CNT_W-1:0] = rs_q.cmpv;
            default:    bus_rdata = '0;
        endcase
        irq = rs_q.chf && rs_q.ie;
    end

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && count == rs_q.modv) |=> rs_q.ovf); // R4
    AST_COUNT_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_COUNT) |=> (count == '0)); // R5
    AST_NO_FLAG_OFF_MODE: assert property (@(posedge clk) disable iff (rst)
        (!rs_q.chf && rs_q.mode != MODE_SWCMP) |=> !rs_q.chf); // R6
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq && !bus_we) |=> irq); // R8
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    localparam int W = 16;
    localparam int MAXC = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    cmp_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference
    int m_cnt, m_mod, m_cmp, m_pre, m_ps, m_mode;
    bit m_run, m_ovf, m_chf, m_ie;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_mod = MAXC; m_cmp = 0; m_pre = 0; m_ps = 0; m_mode = 0;
            m_run = 0; m_ovf = 0; m_chf = 0; m_ie = 0;
        end else begin
            bit zap, tk, wr_hit, mt;
            int nxt, per;
            zap = bus_we && bus_addr == 8'h14;
            per = 1 << m_ps;
            tk = m_run && !zap && ((m_pre % per) == per - 1);
            wr_hit = tk && (m_cnt == m_mod);
            if (zap) nxt = 0;
            else if (wr_hit) nxt = 0;
            else if (tk) nxt = (m_cnt + 1) % (MAXC + 1);
            else nxt = m_cnt;
            mt = tk && (m_mode == 4) && (nxt == m_cmp);
            m_pre = (zap || !m_run) ? 0 : (m_pre + 1) % 128;
            if (bus_we && bus_addr == 8'h10) begin
                m_run = bus_wdata[3];
                m_ps = int'(bus_wdata[2:0]);
                if (bus_wdata[7]) m_ovf = 0;
            end
            if (wr_hit) m_ovf = 1;
            if (bus_we && bus_addr == 8'h18) m_mod = int'(bus_wdata[W-1:0]);
            if (bus_we && bus_addr == 8'h24) m_cmp = int'(bus_wdata[W-1:0]);
            if (bus_we && bus_addr == 8'h20) begin
                m_mode = int'(bus_wdata[5:2]);
                m_ie = bus_wdata[6];
                if (bus_wdata[7]) m_chf = 0;
            end
            if (bus_we && bus_addr == 8'h1C && bus_wdata[0]) m_chf = 0;
            if (mt) m_chf = 1;   // R10: a match outranks a clear
            m_cnt = nxt;
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h04: return 32'(W) << 16;
            8'h10: return 32'({m_ovf, 3'b000, m_run} << 3) | 32'(m_ps);
            8'h14: return 32'(m_cnt);
            8'h18: return 32'(m_mod);
            8'h1C: return 32'(m_chf);
            8'h20: return (32'(m_chf) << 7) | (32'(m_ie) << 6) | (32'(m_mode) << 2);
            8'h24: return 32'(m_cmp);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h04, 8'h18, 8'h24: return "R1";
            8'h10: return "R4";
            8'h14: return "R3";
            8'h1C: return "R7";
            8'h20: return "R6";
            default: return "R9";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(posedge clk) begin
        if (mon_on && !ended) begin
            logic [31:0] exp_rd;
            #2;
            exp_rd = model_rd(bus_addr);
            n_cmp++;
            if (bus_rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s addr %h: rdata actual %h expected %h",
                         tag_of(bus_addr), bus_addr, bus_rdata, exp_rd);
            end
            n_cmp++;
            if (irq !== (m_chf && m_ie)) begin
                n_bad++;
                $display("FAIL R8: irq actual %b expected %b", irq, m_chf && m_ie);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic watch(input logic [7:0] a, input int n);
        @(negedge clk);
        bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        #1;
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        expect_rd(8'h04, 32'h0010_0000, "R1");
        expect_rd(8'h10, 32'h0, "R1");
        expect_rd(8'h18, 32'h0000_FFFF, "R1");
        expect_rd(8'h20, 32'h0, "R1");
        n_cmp++;
        if (irq !== 1'b0) begin n_bad++; $display("FAIL R1: irq actual %b expected 0", irq); end
        mon_on = 1'b1;

        // R9: unmapped and unused bits
        wr(8'h08, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h0, "R9");
        wr(8'h10, 32'hFFFF_FF70);
        expect_rd(8'h10, 32'h0, "R9");
        wr(8'h04, 32'hFFFF_FFFF);
        expect_rd(8'h04, 32'h0010_0000, "R9");
        wr(8'h24, 32'hABCD_1234);
        expect_rd(8'h24, 32'h0000_1234, "R9");

        // R2: stopped counter holds
        expect_rd(8'h14, 32'h0, "R2");
        repeat (10) @(negedge clk);
        expect_rd(8'h14, 32'h0, "R2");

        // R4: wrap and overflow flag with code 0
        wr(8'h18, 32'd5);
        wr(8'h10, 32'h0000_0008);
        watch(8'h14, 20);
        watch(8'h10, 3);
        wr(8'h10, 32'h0000_0008);          // writing 0 to flag keeps it
        wr(8'h10, 32'h0000_0088);          // write one clears

        // R3: prescaler code 3 and code 7
        wr(8'h18, 32'h0000_FFFF);
        wr(8'h10, 32'h0000_000B);
        wr(8'h14, 32'h0000_5555);          // R5 restart
        watch(8'h14, 60);
        wr(8'h10, 32'h0000_000F);
        watch(8'h14, 400);

        // R2 / R5: stop, capture, write count
        wr(8'h10, 32'h0000_0000);
        bus_addr = 8'h14; #1; held = bus_rdata;
        repeat (8) @(negedge clk);
        expect_rd(8'h14, held, "R2");
        wr(8'h14, 32'hFFFF_FFFF);
        expect_rd(8'h14, 32'h0, "R5");

        // R6 / R8: compare match with interrupt
        wr(8'h18, 32'd20);
        wr(8'h24, 32'd7);
        wr(8'h20, 32'h0000_0050);          // mode 4, enable
        wr(8'h10, 32'h0000_0009);          // run, divide by 2
        watch(8'h20, 30);
        n_cmp++;
        if (irq !== 1'b1) begin n_bad++; $display("FAIL R8: irq actual %b expected 1", irq); end
        wr(8'h1C, 32'h0000_0000);          // R7: zero does not clear
        watch(8'h1C, 2);
        wr(8'h1C, 32'h0000_0001);          // R7: clear via status
        watch(8'h20, 40);
        wr(8'h20, 32'h0000_00D0);          // R7: clear via channel bit 7
        watch(8'h1C, 5);

        // R10: clear every other cycle while matches keep happening
        wr(8'h10, 32'h0000_0008);
        wr(8'h18, 32'd3);
        wr(8'h24, 32'd1);
        for (int i = 0; i < 16; i++) wr(8'h1C, 32'h1);

        // R10: directed simultaneous match and clear
        wr(8'h10, 32'h0000_0000);
        wr(8'h18, 32'd50);
        wr(8'h1C, 32'h1);
        wr(8'h14, 32'h0);
        wr(8'h24, 32'd2);
        wr(8'h10, 32'h0000_0008);
        wr(8'h1C, 32'h1);
        expect_rd(8'h1C, 32'h1, "R10");
        wr(8'h10, 32'h0000_0000);

        // R6: mode 0 never flags
        wr(8'h1C, 32'h1);
        wr(8'h20, 32'h0000_0040);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h0000_0008);
        watch(8'h20, 120);
        expect_rd(8'h20, 32'h0000_0040, "R6");
        n_cmp++;
        if (irq !== 1'b0) begin n_bad++; $display("FAIL R6: irq actual %b expected 0", irq); end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule